// File: doc/BRIEF.md
# Variable-Size Region Allocator

This block hands out variable-sized blocks of words from a small table of free regions. Each table slot has a valid flag, a base address and a size in words. A request gives a block size and a policy bit. With the bit low, the block takes the first region in slot order that is large enough. With the bit high, it looks at every slot and takes the region that leaves the least space over. Allocation is non-preemptive: a granted block is carved from the low end of its region and is never moved or given back.

The search steps through one slot per clock. A first-fit search stops on its first match. A best-fit search, and any search that fails, runs to the last slot. The result comes back on a valid/ready response channel. It carries either the granted base address or a fail flag. The table's contents at reset come from parameters, so each instance starts from a known set of free regions. Freeing regions, merging neighbours and compaction are not part of this block.

Top module: `region_alloc`

## Requirements
- R1: When `req_best`=0 (first-fit), the grant goes to the lowest-index slot that is valid and whose size is at least `req_size`. `rsp_base` returns that slot's base.
- R2: When `req_best`=1 (best-fit), every slot is examined. The grant goes to the valid slot with size >= `req_size` whose value of size minus `req_size` is smallest. When two slots tie, the lower index wins.
- R3: After a grant, the chosen slot's base grows by `req_size` and its size shrinks by `req_size`. A slot whose size reaches zero becomes invalid and is never granted again.
- R4: When no valid slot is large enough, the response has `rsp_fail`=1 and `rsp_base`=0, and the table is left exactly as it was.
- R5: Counted in rising clock edges after the edge that accepts the request, `rsp_valid` rises after k+1 edges for a first-fit hit in slot k. It rises after ENTRIES edges for a best-fit request, and for any failed request.
- R6: `req_ready` is high only while no search is running and no response is pending. A request is accepted on a rising edge with `req_valid` and `req_ready` both high. `rsp_base` and `rsp_fail` hold steady while `rsp_valid`=1 and `rsp_ready`=0.
- R7: While reset is low, and right after it is released, the table holds its parameter contents (slot e takes bits [e*width +: width] of each init vector), `req_ready`=1 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_size | input | SW | Requested block size in words |
| req_best | input | 1 | Policy: 0 first-fit, 1 best-fit |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_base | output | AW | Granted base address (0 on failure) |
| rsp_fail | output | 1 | No region was large enough |

## Verification
The bench builds the block with its default parameters: eight slots of 16-bit base and size. Three regions are seeded (base 0 size 50, base 300 size 400, base 800 size 200), and the other five slots are invalid. Because of those invalid trailing slots, every full scan has to pass over empty slots, so the full-scan latency of eight cycles can be checked. The 50-word region can be drained to zero by a sequence of grants, and the best-fit tie between slot 0 and slot 2 can be set up. Because the seeded sizes differ, the same pair of requests lands at different addresses under the two policies.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RESP = 2'd2
  } scan_state_t;
endpackage

// File: rtl/region_table.sv
// Storage for the free-region slots, with one read port addressed by the
// scanner and one shrink port that trims a single slot.
module region_table #(
  parameter int ENTRIES = 8,
  parameter int AW      = 16,
  parameter int SW      = 16,
  parameter int IW      = 3,
  parameter logic [ENTRIES*AW-1:0] INIT_BASE  = '0,
  parameter logic [ENTRIES*SW-1:0] INIT_SIZE  = '0,
  parameter logic [ENTRIES-1:0]    INIT_VALID = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IW-1:0]         rd_idx,
  output logic                  rd_valid,
  output logic [AW-1:0]         rd_base,
  output logic [SW-1:0]         rd_size,
  input  logic                  upd_en,
  input  logic [IW-1:0]         upd_idx,
  input  logic [SW-1:0]         upd_amt,
  output logic [ENTRIES-1:0]    tbl_valid,
  output logic [ENTRIES*AW-1:0] tbl_base_flat,
  output logic [ENTRIES*SW-1:0] tbl_size_flat
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic          v_q;
    logic [AW-1:0] b_q;
    logic [SW-1:0] s_q;
    logic          hit;
    logic [SW-1:0] s_rem;

    assign hit   = upd_en && (upd_idx == IW'(e));
    assign s_rem = s_q - upd_amt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= INIT_VALID[e];
        b_q <= INIT_BASE[e*AW +: AW];
        s_q <= INIT_SIZE[e*SW +: SW];
      end else if (hit) begin
        v_q <= (s_rem != '0);
        b_q <= b_q + AW'(upd_amt);
        s_q <= s_rem;
      end
    end

    assign tbl_valid[e]              = v_q;
    assign tbl_base_flat[e*AW +: AW] = b_q;
    assign tbl_size_flat[e*SW +: SW] = s_q;
  end

  assign rd_valid = tbl_valid[rd_idx];
  assign rd_base  = tbl_base_flat[rd_idx*AW +: AW];
  assign rd_size  = tbl_size_flat[rd_idx*SW +: SW];

endmodule

// File: rtl/fit_eval.sv
// Judges the slot under the scanner against the request and the best
// candidate found so far.
module fit_eval #(
  parameter int SW = 16
) (
  input  logic          ent_valid,
  input  logic [SW-1:0] ent_size,
  input  logic [SW-1:0] want,
  input  logic          have_best,
  input  logic [SW-1:0] best_left,
  output logic          fits,
  output logic [SW-1:0] leftover,
  output logic          better
);
  always_comb begin
    fits     = ent_valid && (ent_size >= want);
    leftover = ent_size - want;
    // Strict less-than keeps the earlier slot on a tie.
    better   = fits && (!have_best || (leftover < best_left));
  end
endmodule

// File: rtl/fit_scan.sv
// Sequencer: accepts a request, walks the slots one per clock, commits the
// shrink and presents the result until it is taken.
module fit_scan
  import alloc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 16,
  parameter int SW      = 16,
  parameter int IW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [SW-1:0] req_size,
  input  logic          req_best,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_base,
  output logic          rsp_fail,
  output logic [IW-1:0] rd_idx,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_base,
  input  logic [SW-1:0] rd_size,
  output logic          upd_en,
  output logic [IW-1:0] upd_idx,
  output logic [SW-1:0] upd_amt
);
  localparam logic [IW-1:0] LAST_IDX = IW'(ENTRIES - 1);

  scan_state_t   state_q, state_d;
  logic [IW-1:0] idx_q;
  logic [SW-1:0] sz_q;
  logic          bf_q;
  logic          have_q;
  logic [IW-1:0] bidx_q;
  logic [SW-1:0] bleft_q;
  logic [AW-1:0] bbase_q;
  logic [AW-1:0] obase_q;
  logic          ofail_q;

  logic          fits, better;
  logic [SW-1:0] leftover;
  logic          accept, scanning, ff_hit, last, done;
  logic          sel_found;
  logic [IW-1:0] sel_idx;
  logic [AW-1:0] sel_base;

  fit_eval #(.SW(SW)) eval_i (
    .ent_valid (rd_valid),
    .ent_size  (rd_size),
    .want      (sz_q),
    .have_best (have_q),
    .best_left (bleft_q),
    .fits      (fits),
    .leftover  (leftover),
    .better    (better)
  );

  always_comb begin
    accept    = (state_q == ST_IDLE) && req_valid;
    scanning  = (state_q == ST_SCAN);
    ff_hit    = !bf_q && fits;
    last      = (idx_q == LAST_IDX);
    done      = scanning && (ff_hit || last);
    sel_found = have_q || better;
    sel_idx   = better ? idx_q : bidx_q;
    sel_base  = better ? rd_base : bbase_q;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)    state_d = ST_SCAN;
      ST_SCAN: if (done)      state_d = ST_RESP;
      ST_RESP: if (rsp_ready) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sz_q    <= '0;
      bf_q    <= 1'b0;
      have_q  <= 1'b0;
      bidx_q  <= '0;
      bleft_q <= '0;
      bbase_q <= '0;
      obase_q <= '0;
      ofail_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        sz_q   <= req_size;
        bf_q   <= req_best;
        idx_q  <= '0;
        have_q <= 1'b0;
      end
      if (scanning && !done) begin
        idx_q <= idx_q + 1'b1;
        if (better) begin
          have_q  <= 1'b1;
          bidx_q  <= idx_q;
          bleft_q <= leftover;
          bbase_q <= rd_base;
        end
      end
      if (done) begin
        obase_q <= sel_found ? sel_base : '0;
        ofail_q <= !sel_found;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_base  = obase_q;
  assign rsp_fail  = ofail_q;
  assign rd_idx    = idx_q;
  assign upd_en    = done && sel_found;
  assign upd_idx   = sel_idx;
  assign upd_amt   = sz_q;

endmodule

// File: rtl/region_alloc.sv
module region_alloc #(
  parameter int ENTRIES = 8,
  parameter int AW      = 16,
  parameter int SW      = 16,
  parameter logic [ENTRIES*AW-1:0] INIT_BASE =
    {16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd800, 16'd300, 16'd0},
  parameter logic [ENTRIES*SW-1:0] INIT_SIZE =
    {16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd200, 16'd400, 16'd50},
  parameter logic [ENTRIES-1:0] INIT_VALID = 8'b0000_0111
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [SW-1:0] req_size,
  input  logic          req_best,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_base,
  output logic          rsp_fail
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IW-1:0]         rd_idx;
  logic                  rd_valid;
  logic [AW-1:0]         rd_base;
  logic [SW-1:0]         rd_size;
  logic                  upd_en;
  logic [IW-1:0]         upd_idx;
  logic [SW-1:0]         upd_amt;
  logic [ENTRIES-1:0]    tbl_valid;
  logic [ENTRIES*AW-1:0] tbl_base_flat;
  logic [ENTRIES*SW-1:0] tbl_size_flat;

  region_table #(
    .ENTRIES(ENTRIES), .AW(AW), .SW(SW), .IW(IW),
    .INIT_BASE(INIT_BASE), .INIT_SIZE(INIT_SIZE), .INIT_VALID(INIT_VALID)
  ) table_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_idx        (rd_idx),
    .rd_valid      (rd_valid),
    .rd_base       (rd_base),
    .rd_size       (rd_size),
    .upd_en        (upd_en),
    .upd_idx       (upd_idx),
    .upd_amt       (upd_amt),
    .tbl_valid     (tbl_valid),
    .tbl_base_flat (tbl_base_flat),
    .tbl_size_flat (tbl_size_flat)
  );

  fit_scan #(
    .ENTRIES(ENTRIES), .AW(AW), .SW(SW), .IW(IW)
  ) scan_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_size  (req_size),
    .req_best  (req_best),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_base  (rsp_base),
    .rsp_fail  (rsp_fail),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_base   (rd_base),
    .rd_size   (rd_size),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_amt   (upd_amt)
  );

endmodule

// File: rtl/region_alloc_chk.sv
module region_alloc_chk #(
  parameter int ENTRIES = 8,
  parameter int AW      = 16,
  parameter int SW      = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [AW-1:0]         rsp_base,
  input logic                  rsp_fail,
  input logic [ENTRIES-1:0]    tbl_valid,
  input logic [ENTRIES*AW-1:0] tbl_base_flat,
  input logic [ENTRIES*SW-1:0] tbl_size_flat
);
  logic zero_valid;
  always_comb begin
    zero_valid = 1'b0;
    for (int e = 0; e < ENTRIES; e++)
      if (tbl_valid[e] && (tbl_size_flat[e*SW +: SW] == '0)) zero_valid = 1'b1;
  end

  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_base) && $stable(rsp_fail)));

  assert_fail_keeps_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_fail) |-> ($stable(tbl_base_flat) && $stable(tbl_size_flat)
                                        && $stable(tbl_valid)));

  assert_fail_base_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fail) |-> (rsp_base == '0));

  assert_no_empty_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_valid);
endmodule

bind region_alloc region_alloc_chk #(.ENTRIES(ENTRIES), .AW(AW), .SW(SW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_base      (rsp_base),
  .rsp_fail      (rsp_fail),
  .tbl_valid     (tbl_valid),
  .tbl_base_flat (tbl_base_flat),
  .tbl_size_flat (tbl_size_flat)
);

// File: tb/region_alloc_tb_top.sv
`timescale 1ns/1ps
module region_alloc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_best, rsp_ready;
  logic [15:0] req_size;
  logic        req_ready, rsp_valid, rsp_fail;
  logic [15:0] rsp_base;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  region_alloc dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_best(req_best),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_base(rsp_base), .rsp_fail(rsp_fail)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_best = 1'b0; req_size = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One request; latency counted in edges after the accepting edge.
  task automatic do_req(input int sz, input bit bf, input bit efail,
                        input int ebase, input int elat, input string rq);
    int lat;
    @(negedge clk);
    req_size = 16'(sz); req_best = bf; req_valid = 1'b1; rsp_ready = 1'b1;
    chk(req_ready == 1'b1, rq, "req_ready before request", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    chk(rsp_fail == efail, rq, "rsp_fail", int'(rsp_fail), int'(efail));
    chk(int'(rsp_base) == ebase, rq, "rsp_base", int'(rsp_base), ebase);
    chk(lat == elat, {rq, " R5"}, "latency", lat, elat);
  endtask

  task automatic test_reset_R7();
    do_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "req_ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R7", "rsp_valid after reset", int'(rsp_valid), 0);
    // Seeded table: the first slot holds base 0, size 50
    do_req(50, 1'b0, 1'b0, 0, 1, "R7");
  endtask

  task automatic test_first_fit_R1();
    do_reset();
    do_req(100, 1'b0, 1'b0, 300, 2, "R1");
    do_req(250, 1'b0, 1'b0, 400, 2, "R1");
    do_req(30,  1'b0, 1'b0, 0,   1, "R1");
    do_req(20,  1'b0, 1'b0, 30,  1, "R3");   // drains slot 0 to zero
    do_req(0,   1'b0, 1'b0, 650, 2, "R3");   // slot 0 now invalid, skipped
    do_req(50,  1'b0, 1'b0, 650, 2, "R3");
    do_req(10,  1'b0, 1'b0, 800, 3, "R3");   // slot 1 drained
  endtask

  task automatic test_best_fit_R2();
    do_reset();
    do_req(100, 1'b1, 1'b0, 800, 8, "R2");
    do_req(250, 1'b1, 1'b0, 300, 8, "R2");
    do_reset();
    do_req(150, 1'b1, 1'b0, 800, 8, "R2");
    do_req(50,  1'b1, 1'b0, 0,   8, "R2");   // tie slot 0 / slot 2 -> lower
    do_req(50,  1'b1, 1'b0, 950, 8, "R2");
    do_req(50,  1'b1, 1'b0, 300, 8, "R3");
  endtask

  task automatic test_fail_R4();
    do_reset();
    do_req(401, 1'b0, 1'b1, 0, 8, "R4");
    do_req(401, 1'b1, 1'b1, 0, 8, "R4");
    do_req(400, 1'b0, 1'b0, 300, 2, "R4");   // table untouched by failures
    do_req(201, 1'b1, 1'b1, 0, 8, "R4");
    do_req(200, 1'b1, 1'b0, 800, 8, "R4");
  endtask

  task automatic test_backpressure_R6();
    logic [15:0] held;
    do_reset();
    @(negedge clk);
    req_size = 16'd10; req_best = 1'b0; req_valid = 1'b1; rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b0, "R6", "req_ready while scanning", int'(req_ready), 0);
    req_size = 16'd60;                       // stays valid, must not be taken
    @(posedge clk); @(negedge clk);
    chk(rsp_valid == 1'b1, "R6", "rsp_valid", int'(rsp_valid), 1);
    held = rsp_base;
    chk(held == 16'd0, "R6", "rsp_base", int'(held), 0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk(rsp_valid && rsp_base == held && !rsp_fail, "R6", "held response",
          int'(rsp_base), int'(held));
      chk(req_ready == 1'b0, "R6", "req_ready while pending", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(rsp_valid == 1'b0, "R6", "rsp_valid after take", int'(rsp_valid), 0);
    do_req(40, 1'b0, 1'b0, 10, 1, "R6");     // only the 10-word grant happened
  endtask

  initial begin
    test_reset_R7();
    test_first_fit_R1();
    test_best_fit_R2();
    test_fail_R4();
    test_backpressure_R6();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule